// File: doc/BRIEF.md
# Outer-Product Fixed-Point Matrix Engine

This block computes C = A·B, where A has ROWS rows and B has COLS columns, and every element of both operands is a 32-bit signed value. The engine takes one step per accepted input beat. On step k it receives one column of A and the matching row of B. Every element of the ROWS×COLS result grid then adds its own outer-product term. All elements update in the same cycle, so no reduction tree is needed and the operands need no padding. The number of steps K is set by the caller, who marks the final beat.

Each result element does not run a signed multiply-accumulate. It keeps four unsigned sums of 16×16 half-products, two 40-bit sign-correction sums and an 8-bit count of steps in which both operands were negative. After the last step these sums are merged once into the exact 80-bit signed result. The grid then drains one element per cycle in row-major order. Each element appears on two outputs at the same time: the full 80-bit integer, and a 32-bit value in 16.16 fixed-point format taken from that integer.

Top module: `opmat_engine`

## Requirements
- R1: For K from 1 to 255 steps, each drained element on `out_wide` equals the sum over k of A(i,k)·B(k,j), taken as signed 32-bit operands, modulo 2^80. This holds when every operand is negative.
- R2: `out_fixed` equals bits 47..16 of `out_wide` for the element being drained. The higher bits are dropped without any check.
- R3: On an accepted beat, `in_col[32*i +: 32]` is A(i,k) and `in_row[32*j +: 32]` is B(k,j). Beats are consumed in arrival order.
- R4: An accepted beat with `in_last` high starts the drain on the next cycle. `out_valid` is then high for exactly ROWS·COLS consecutive cycles, and element (i,j) appears in the cycle with index i·COLS+j. After that, `out_valid` falls and `in_ready` rises.
- R5: While `out_valid` is high, `in_ready` is low. Any `in_valid` beat offered during the drain is ignored and does not change the results.
- R6: The first accepted beat after reset, or after a drain, replaces all sums instead of adding to them. Back-to-back matrices are therefore independent.
- R7: After reset, `out_valid` is low and `in_ready` is high.
- R8: The count of both-negative steps is applied at weight 2^64, so all-negative operands, including the most negative value, give exact results.
- R9: A matrix of a single beat, with `in_last` set on the first beat, gives A(i,0)·B(0,j).
- R10: Cycles with `in_valid` low between beats do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A column/row beat is offered |
| in_last | input | 1 | The offered beat is the last step of the matrix |
| in_col | input | ROWS*32 | Column k of A, lane i holds A(i,k) |
| in_row | input | COLS*32 | Row k of B, lane j holds B(k,j) |
| in_ready | output | 1 | High while beats are being accepted |
| out_valid | output | 1 | A result element is on the outputs |
| out_wide | output | 80 | Exact 80-bit result element |
| out_fixed | output | 32 | 16.16 fixed-point view of the same element |

## Verification
The assertions assume that each matrix has no more than 255 steps. Above that, the both-negative counter and the correction sums would wrap, and the exactness argument would fail. They also assume that `in_last` is only ever presented together with `in_valid`. The bench keeps every matrix within these limits, with K between 1 and 200. It drives beats only while `in_ready` is high, except in one scenario that deliberately offers junk beats during the drain. Expected values come from a 128-bit signed sum of products computed in the bench. The corner scenarios use all-minus-one and all-most-negative operands.

// File: rtl/opmat_pkg.sv
// Package: opmat_pkg
// Shared widths and the phase type for the outer-product matrix engine.
// Assumes operands are 32-bit two's-complement words split into 16-bit halves.
package opmat_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned HALF_W = WORD_W / 2;

    typedef enum logic {
        PH_ACCUM = 1'b0,
        PH_DRAIN = 1'b1
    } phase_t;
endpackage

// File: rtl/opmat_cell.sv
// Module: opmat_cell
// One result element. Keeps four unsigned half-product sums, two sign
// correction sums and a both-negative step count, then merges them into
// the exact signed result modulo 2^RES_W.
// Assumes at most 2^CNT_W - 1 steps per matrix and RES_W >= 4*HALF_W.
module opmat_cell
    import opmat_pkg::*;
#(
    parameter int unsigned ACC_W  = 48,
    parameter int unsigned CORR_W = 40,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned RES_W  = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              step_clr,
    input  logic [WORD_W-1:0] a_val,
    input  logic [WORD_W-1:0] b_val,
    output logic [RES_W-1:0]  acc_out
);
    logic [HALF_W-1:0]   a_lo, a_hi, b_lo, b_hi;
    logic [2*HALF_W-1:0] p_ll, p_hl, p_lh, p_hh;
    logic [ACC_W-1:0]    sum_ll, sum_hl, sum_lh, sum_hh;
    logic [CORR_W-1:0]   sum_da, sum_db;
    logic [CNT_W-1:0]    sum_s;
    logic [RES_W-1:0]    mid, uns, corr;

    // Split the operands and form the four unsigned half products.
    always_comb begin
        a_lo = a_val[HALF_W-1:0];
        a_hi = a_val[WORD_W-1:HALF_W];
        b_lo = b_val[HALF_W-1:0];
        b_hi = b_val[WORD_W-1:HALF_W];
        p_ll = a_lo * b_lo;
        p_hl = a_hi * b_lo;
        p_lh = a_lo * b_hi;
        p_hh = a_hi * b_hi;
    end

    // Accumulate one outer-product term; the first step of a matrix overwrites.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_ll <= '0;
            sum_hl <= '0;
            sum_lh <= '0;
            sum_hh <= '0;
            sum_da <= '0;
            sum_db <= '0;
            sum_s  <= '0;
        end else if (step_en) begin
            sum_ll <= (step_clr ? '0 : sum_ll) + ACC_W'(p_ll);
            sum_hl <= (step_clr ? '0 : sum_hl) + ACC_W'(p_hl);
            sum_lh <= (step_clr ? '0 : sum_lh) + ACC_W'(p_lh);
            sum_hh <= (step_clr ? '0 : sum_hh) + ACC_W'(p_hh);
            sum_da <= (step_clr ? '0 : sum_da) + (a_val[WORD_W-1] ? CORR_W'(b_val) : '0);
            sum_db <= (step_clr ? '0 : sum_db) + (b_val[WORD_W-1] ? CORR_W'(a_val) : '0);
            sum_s  <= (step_clr ? '0 : sum_s)  + CNT_W'(a_val[WORD_W-1] & b_val[WORD_W-1]);
        end
    end

    // Merge shifted partial sums and apply sign corrections once.
    always_comb begin
        mid     = RES_W'(sum_hl) + RES_W'(sum_lh);
        uns     = RES_W'(sum_ll) + (mid << HALF_W) + (RES_W'(sum_hh) << (2*HALF_W));
        corr    = (RES_W'(sum_da) + RES_W'(sum_db)) << (2*HALF_W);
        acc_out = uns - corr + (RES_W'(sum_s) << (4*HALF_W));
    end

    AST_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(sum_ll) && $stable(sum_hh) && $stable(sum_da) && $stable(sum_s)); // R5
    AST_FIRST_STEP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        step_en && step_clr |=> sum_s == CNT_W'($past(a_val[WORD_W-1] & b_val[WORD_W-1]))); // R6
    AST_BOTH_NEG_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        step_en && !step_clr && a_val[WORD_W-1] && b_val[WORD_W-1]
        |=> sum_s == $past(sum_s) + 1'b1); // R8
endmodule

// File: rtl/opmat_seq.sv
// Module: opmat_seq
// Step/drain sequencer. Accepts beats while accumulating, switches to the
// drain on an accepted last beat, and walks the element index in raster order.
// Assumes in_last is only meaningful together with in_valid.
module opmat_seq
    import opmat_pkg::*;
#(
    parameter int unsigned ELEMS = 16,
    localparam int unsigned IDX_W = (ELEMS > 1) ? $clog2(ELEMS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_last,
    output logic             in_ready,
    output logic             step_en,
    output logic             step_clr,
    output logic             out_valid,
    output logic [IDX_W-1:0] out_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ELEMS - 1);

    phase_t phase;
    logic   fresh;

    // Phase, drain index and first-step flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_ACCUM;
            out_idx <= '0;
            fresh   <= 1'b1;
        end else if (phase == PH_ACCUM) begin
            if (in_valid) begin
                fresh <= 1'b0;
                if (in_last) begin
                    phase   <= PH_DRAIN;
                    out_idx <= '0;
                end
            end
        end else if (out_idx == LAST_IDX) begin
            phase   <= PH_ACCUM;
            out_idx <= '0;
            fresh   <= 1'b1;
        end else begin
            out_idx <= out_idx + 1'b1;
        end
    end

    // Handshake and step controls derived from the phase.
    always_comb begin
        in_ready  = (phase == PH_ACCUM);
        step_en   = in_ready && in_valid;
        step_clr  = fresh;
        out_valid = (phase == PH_DRAIN);
    end

    AST_LAST_OPENS_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_last |=> out_valid && out_idx == '0); // R4
    AST_RASTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_idx != LAST_IDX |=> out_valid && out_idx == $past(out_idx) + 1'b1); // R4
    AST_DRAIN_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_idx == LAST_IDX |=> !out_valid && in_ready && step_clr); // R6
endmodule

// File: rtl/opmat_engine.sv
// Module: opmat_engine
// Outer-product matrix engine: a ROWS x COLS grid of cells fed by one column
// of A and one row of B per step, drained in raster order after the last step.
// Assumes at most 255 steps per matrix with the default widths.
module opmat_engine
    import opmat_pkg::*;
#(
    parameter int unsigned ROWS   = 4,
    parameter int unsigned COLS   = 4,
    parameter int unsigned ACC_W  = 48,
    parameter int unsigned CORR_W = 40,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned FRAC_W = 16,
    localparam int unsigned RES_W = ACC_W + 2*HALF_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_last,
    input  logic [ROWS*WORD_W-1:0] in_col,
    input  logic [COLS*WORD_W-1:0] in_row,
    output logic                   in_ready,
    output logic                   out_valid,
    output logic [RES_W-1:0]       out_wide,
    output logic [WORD_W-1:0]      out_fixed
);
    localparam int unsigned ELEMS = ROWS * COLS;
    localparam int unsigned IDX_W = (ELEMS > 1) ? $clog2(ELEMS) : 1;

    logic             step_en, step_clr;
    logic [IDX_W-1:0] out_idx;
    logic [RES_W-1:0] cell_res [ELEMS];

    opmat_seq #(.ELEMS(ELEMS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .step_en   (step_en),
        .step_clr  (step_clr),
        .out_valid (out_valid),
        .out_idx   (out_idx)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            opmat_cell #(
                .ACC_W (ACC_W),
                .CORR_W(CORR_W),
                .CNT_W (CNT_W),
                .RES_W (RES_W)
            ) u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .step_en (step_en),
                .step_clr(step_clr),
                .a_val   (in_col[r*WORD_W +: WORD_W]),
                .b_val   (in_row[c*WORD_W +: WORD_W]),
                .acc_out (cell_res[r*COLS + c])
            );
        end
    end

    // Select the element being drained and take its fixed-point window.
    always_comb begin
        out_wide  = cell_res[out_idx];
        out_fixed = out_wide[FRAC_W +: WORD_W];
    end

    AST_NO_ACCEPT_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R5
endmodule

// File: tb/opmat_engine_bench.sv
// Directed bench for opmat_engine; each scenario task checks its own results.
module opmat_engine_bench;
    localparam int  M      = 4;
    localparam int  N      = 4;
    localparam int  KMAX   = 256;
    localparam time CLK_T  = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_last = 1'b0;
    logic [M*32-1:0] in_col = '0;
    logic [N*32-1:0] in_row = '0;
    logic          in_ready, out_valid;
    logic [79:0]   out_wide;
    logic [31:0]   out_fixed;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    int a_m [M][KMAX];
    int b_m [KMAX][N];

    opmat_engine u_opmat_engine (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
        .in_col(in_col), .in_row(in_row), .in_ready(in_ready),
        .out_valid(out_valid), .out_wide(out_wide), .out_fixed(out_fixed)
    );

    always #(CLK_T/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] ref_elem(input int i, input int j, input int kk);
        logic [127:0] acc = '0;
        for (int k = 0; k < kk; k++) begin
            longint p = longint'(a_m[i][k]) * longint'(b_m[k][j]);
            acc = acc + {{64{p[63]}}, p};
        end
        return acc;
    endfunction

    task automatic fill_random(input int kk);
        for (int k = 0; k < kk; k++) begin
            for (int i = 0; i < M; i++) a_m[i][k] = $random;
            for (int j = 0; j < N; j++) b_m[k][j] = $random;
        end
    endtask

    task automatic fill_const(input int kk, input int val);
        for (int k = 0; k < kk; k++) begin
            for (int i = 0; i < M; i++) a_m[i][k] = val;
            for (int j = 0; j < N; j++) b_m[k][j] = val;
        end
    endtask

    // Feed kk beats (optional idle gaps), drain and compare every element.
    task automatic run_matrix(input int kk, input int gap, input bit junk, input string tag);
        logic [127:0] e;
        for (int k = 0; k < kk; k++) begin
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_col   = {M{32'hDEAD_BEEF}};
            end
            @(negedge clk);
            chk(in_ready == 1'b1, {tag, " R5 ready before beat"}, 128'(in_ready), 128'(1));
            in_valid = 1'b1;
            in_last  = (k == kk - 1);
            for (int i = 0; i < M; i++) in_col[i*32 +: 32] = a_m[i][k];
            for (int j = 0; j < N; j++) in_row[j*32 +: 32] = b_m[k][j];
            @(posedge clk);
        end
        @(negedge clk);
        in_last  = 1'b0;
        in_valid = junk;
        in_col   = {M{32'h8000_0001}};
        in_row   = {N{32'hFFFF_FFFF}};
        for (int e_i = 0; e_i < M*N; e_i++) begin
            e = ref_elem(e_i / N, e_i % N, kk);
            chk(out_valid == 1'b1, {tag, " R4 valid during drain"}, 128'(out_valid), 128'(1));
            chk(in_ready == 1'b0, {tag, " R5 not ready during drain"}, 128'(in_ready), 128'(0));
            chk(out_wide == e[79:0], {tag, " R1/R3 wide element"}, 128'(out_wide), 128'(e[79:0]));
            chk(out_fixed == e[47:16], {tag, " R2 fixed element"}, 128'(out_fixed), 128'(e[47:16]));
            @(negedge clk);
        end
        in_valid = 1'b0;
        chk(out_valid == 1'b0, {tag, " R4 drain ends"}, 128'(out_valid), 128'(0));
        chk(in_ready == 1'b1, {tag, " R4 ready after drain"}, 128'(in_ready), 128'(1));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 out_valid after reset", 128'(out_valid), 128'(0));
        chk(in_ready == 1'b1, "R7 in_ready after reset", 128'(in_ready), 128'(1));
    endtask

    task automatic t_small_positive();
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < M; i++) a_m[i][k] = (i + 1) * 65536 + k;
            for (int j = 0; j < N; j++) b_m[k][j] = (j + 2) * 32768 + 3 * k;
        end
        run_matrix(4, 0, 1'b0, "R3 small positive");
    endtask

    task automatic t_random_gaps();
        fill_random(16);
        run_matrix(16, 2, 1'b0, "R10 random with gaps");
    endtask

    task automatic t_all_negative();
        fill_const(8, -1);
        run_matrix(8, 0, 1'b0, "R8 all minus one");
        fill_const(8, int'(32'h8000_0000));
        run_matrix(8, 0, 1'b0, "R8 all most negative");
    endtask

    task automatic t_single_step();
        fill_random(1);
        run_matrix(1, 0, 1'b0, "R9 single step");
    endtask

    task automatic t_junk_and_back_to_back();
        fill_random(6);
        run_matrix(6, 0, 1'b1, "R5 junk during drain");
        fill_random(3);
        run_matrix(3, 1, 1'b0, "R6 back to back");
    endtask

    task automatic t_long();
        fill_random(200);
        run_matrix(200, 0, 1'b0, "R1 long signed");
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_small_positive();
        t_random_gaps();
        t_all_negative();
        t_single_step();
        t_junk_and_back_to_back();
        t_long();
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end
endmodule